// File: doc/BRIEF.md
# GPIO Pad Configuration Bank with Write Lock

This block holds one 32-bit configuration word for each pin of a general-purpose I/O controller and turns those words directly into pin controls. Each word carries the value to drive, a transmit-disable bit, a receive-disable bit and a 4-bit receive trigger-mode field. Bit 1 always shows the pin's input level after a two-flop synchronizer. The transmit-disable bit selects the output enable and bit 0 selects the driven level. The trigger field of every pin goes out on a flat vector to a separate interrupt unit.

A lock bitmap, fixed at build time by a parameter, marks pins whose words software may not change. Writes to a locked pin are dropped without an error, but reads still return the word. Software finds the pad region through a read-only pointer at offset 0x00, which holds the region's byte offset. The lock bitmap is a small read-only region at its own offset. Reads return data one cycle after the request, together with a valid strobe.

The read response is driven by a two-state machine. ST_IDLE moves to ST_RESP when a read is requested (transition RD_ISSUE). ST_RESP stays in ST_RESP while reads keep arriving back to back (RD_CHAIN), and returns to ST_IDLE when no read is requested (RD_DONE). ST_IDLE stays in ST_IDLE with no request (IDLE_HOLD).

Top module: `gpio_padcfg_bank`

## Requirements
- R1: A read of byte address 0x00 returns the parameter PAD_BASE, which is the byte offset of the pad region (default 0x100). Writes to 0x00 change nothing.
- R2: Lock word k sits at LOCK_OFS + 4*k (default LOCK_OFS 0x04, k = 0..3). Bit j of word k is the lock flag of pin 32*k + j, and 1 means locked. The lock words are read-only.
- R3: A write to the word of a locked pin is ignored, and a read of that word still returns its current contents.
- R4: The word of pin p is at PAD_BASE + 4*p. Its fields are: bit 0 drive value, bit 3 transmit disable, bit 4 receive disable, and bits 25:22 trigger mode (0 level, 1 edge, 2 detection off). A write to an unlocked pin stores exactly these bits. All other bits read as 0.
- R5: Bit 1 of a pad word reads the pin input after a two-flop synchronizer. Writes to bit 1 are ignored.
- R6: After reset every pad word holds drive 0, transmit disabled, receive enabled and trigger mode 2 (value 0x00800008 plus bit 1).
- R7: pin_oe[p] is the inverse of bit 3 of pin p's word, pin_out[p] is bit 0, and pin_trig[4p+3:4p] is bits 25:22. These outputs change in the cycle after the write.
- R8: An address outside the pointer, lock and pad regions reads as 0, and a write to it changes no state.
- R9: Read data appears on bus_rdata with bus_rvalid high exactly one cycle after bus_rd. bus_rvalid is low in any cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| pin_in | input | 128 | Raw pin input levels |
| pin_oe | output | 128 | Per-pin output enable |
| pin_out | output | 128 | Per-pin drive value |
| pin_trig | output | 512 | Per-pin 4-bit trigger mode for the interrupt unit |

## Verification
Several rules are checked by assertions on every cycle. These cover the one-cycle read valid timing and the absence of spurious valid strobes. They also check that a locked pin's stored fields never move, that a granted write lands in the stored fields, that the pointer returns its parameter, and that unmapped reads return zero. Other behaviour can only be shown by bench scenarios. These include the field packing of each word and the masking of the read-only input bit. They also include the synchronizer delay seen through a read, the reset contents, the lock bitmap ordering, and agreement of the pin vectors with a reference model across random writes to locked and unlocked pins.

// File: rtl/gpio_padcfg_pkg.sv
package gpio_padcfg_pkg;
    localparam int DRV_BIT   = 0;
    localparam int IN_BIT    = 1;
    localparam int TXDIS_BIT = 3;
    localparam int RXDIS_BIT = 4;
    localparam int TRIG_LSB  = 22;
    localparam int TRIG_W    = 4;

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic              rxdis;
        logic              txdis;
        logic              drv;
    } pad_cfg_t;

    localparam pad_cfg_t PAD_CFG_RST = '{trig: 4'd2, rxdis: 1'b0, txdis: 1'b1, drv: 1'b0};

    function automatic pad_cfg_t cfg_from_word(input logic [31:0] w);
        pad_cfg_t c;
        c.drv   = w[DRV_BIT];
        c.txdis = w[TXDIS_BIT];
        c.rxdis = w[RXDIS_BIT];
        c.trig  = w[TRIG_LSB +: TRIG_W];
        return c;
    endfunction

    function automatic logic [31:0] word_from_cfg(input pad_cfg_t c, input logic in_lvl);
        logic [31:0] w;
        w = '0;
        w[DRV_BIT]             = c.drv;
        w[IN_BIT]              = in_lvl;
        w[TXDIS_BIT]           = c.txdis;
        w[RXDIS_BIT]           = c.rxdis;
        w[TRIG_LSB +: TRIG_W]  = c.trig;
        return w;
    endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
        end
    end

    assign dout = stab_q;
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
    import gpio_padcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  pad_cfg_t wr_cfg,
    input  logic     locked,
    output pad_cfg_t cfg
);
    pad_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= PAD_CFG_RST;
        else if (wr_en)
            cfg_q <= wr_cfg;
    end

    assign cfg = cfg_q;

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cfg_q)); // R3
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == $past(wr_cfg))); // R4
endmodule

// File: rtl/gpio_padcfg_bank.sv
module gpio_padcfg_bank
    import gpio_padcfg_pkg::*;
#(
    parameter int NUM_PINS = 128,
    parameter int ADDR_W   = 12,
    parameter int PAD_BASE = 32'h100,
    parameter int LOCK_OFS = 32'h04,
    parameter logic [NUM_PINS-1:0] LOCK_INIT =
        {32'h8000_0001, 32'h0000_00F0, 32'h0000_0000, 32'h0000_0003}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [31:0]              bus_wdata,
    input  logic                     bus_rd,
    output logic [31:0]              bus_rdata,
    output logic                     bus_rvalid,
    input  logic [NUM_PINS-1:0]      pin_in,
    output logic [NUM_PINS-1:0]      pin_oe,
    output logic [NUM_PINS-1:0]      pin_out,
    output logic [TRIG_W*NUM_PINS-1:0] pin_trig
);
    localparam int PIN_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int LOCK_WORDS = (NUM_PINS + 31) / 32;
    localparam int LW_W       = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
    localparam int PAD_END    = PAD_BASE + 4 * NUM_PINS;
    localparam int LOCK_END   = LOCK_OFS + 4 * LOCK_WORDS;

    typedef enum logic {ST_IDLE, ST_RESP} rd_state_t;
    rd_state_t state_q, state_nx;

    logic [31:0]         addr_ext;
    logic                ptr_hit, lock_hit, pad_hit, map_hit;
    logic [PIN_W-1:0]    pin_idx;
    logic [LW_W-1:0]     lock_idx;
    logic [31:0]         lock_word [LOCK_WORDS];
    logic [NUM_PINS-1:0] in_sync;
    pad_cfg_t            cfg [NUM_PINS];
    pad_cfg_t            wr_cfg;
    logic [31:0]         rd_word;
    logic [31:0]         rdata_q;
    logic                unused_wdata;

    assign addr_ext  = 32'(bus_addr);
    assign ptr_hit   = (addr_ext[31:2] == 30'd0);
    assign lock_hit  = (addr_ext >= 32'(LOCK_OFS)) && (addr_ext < 32'(LOCK_END));
    assign pad_hit   = (addr_ext >= 32'(PAD_BASE)) && (addr_ext < 32'(PAD_END));
    assign map_hit   = ptr_hit | lock_hit | pad_hit;
    assign pin_idx   = PIN_W'((addr_ext - 32'(PAD_BASE)) >> 2);
    assign lock_idx  = LW_W'((addr_ext - 32'(LOCK_OFS)) >> 2);
    assign wr_cfg    = cfg_from_word(bus_wdata);
    assign unused_wdata = ^{bus_wdata[31:26], bus_wdata[21:5], bus_wdata[2:1]};

    always_comb begin
        for (int w = 0; w < LOCK_WORDS; w++) begin
            lock_word[w] = '0;
            for (int b = 0; b < 32; b++)
                if (w * 32 + b < NUM_PINS)
                    lock_word[w][b] = LOCK_INIT[w * 32 + b];
        end
    end

    gpio_sync2 #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (in_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        logic sel_wr;
        assign sel_wr = bus_wr && pad_hit && (pin_idx == PIN_W'(p)) && !LOCK_INIT[p];

        gpio_pad_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (sel_wr),
            .wr_cfg(wr_cfg),
            .locked(LOCK_INIT[p]),
            .cfg   (cfg[p])
        );

        assign pin_oe[p]                   = ~cfg[p].txdis;
        assign pin_out[p]                  = cfg[p].drv;
        assign pin_trig[TRIG_W*p +: TRIG_W] = cfg[p].trig;
    end

    always_comb begin
        rd_word = '0;
        if (ptr_hit)
            rd_word = 32'(PAD_BASE);
        else if (lock_hit)
            rd_word = lock_word[lock_idx];
        else if (pad_hit)
            rd_word = word_from_cfg(cfg[pin_idx], in_sync[pin_idx]);
    end

    // read response state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = bus_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = bus_rd ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_word;
    end

    // outputs of the response machine
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            default: ;
        endcase
    end

    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R9
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !map_hit) |=> (bus_rdata == 32'd0)); // R8
    AST_PTR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ptr_hit) |=> (bus_rdata == 32'(PAD_BASE))); // R1
endmodule

// File: tb/gpio_padcfg_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_padcfg_bank_tb_top;
    localparam int N        = 128;
    localparam int PADB     = 32'h100;
    localparam int LOCKB    = 32'h04;
    localparam logic [N-1:0] LOCKS =
        {32'h8000_0001, 32'h0000_00F0, 32'h0000_0000, 32'h0000_0003};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_oe;
    logic [N-1:0]  pin_out;
    logic [4*N-1:0] pin_trig;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic       m_drv  [N];
    logic       m_txd  [N];
    logic       m_rxd  [N];
    logic [3:0] m_trig [N];

    always #4 clk = ~clk;

    gpio_padcfg_bank #(.NUM_PINS(N), .ADDR_W(12), .PAD_BASE(PADB),
                       .LOCK_OFS(LOCKB), .LOCK_INIT(LOCKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_trig(pin_trig)
    );

    function automatic logic [31:0] exp_word(int p);
        logic [31:0] w = '0;
        w[0]     = m_drv[p];
        w[1]     = pin_in[p];
        w[3]     = m_txd[p];
        w[4]     = m_rxd[p];
        w[25:22] = m_trig[p];
        return w;
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        check32("R9 rvalid after read", 32'(bus_rvalid), 32'd1);
    endtask

    task automatic pad_write(int p, logic [31:0] d);
        do_write(PADB + 4 * p, d);
        if (!LOCKS[p]) begin
            m_drv[p] = d[0]; m_txd[p] = d[3]; m_rxd[p] = d[4]; m_trig[p] = d[25:22];
        end
    endtask

    task automatic check_pins(string req);
        logic [N-1:0] eo, ev;
        logic [4*N-1:0] et;
        for (int p = 0; p < N; p++) begin
            eo[p] = ~m_txd[p]; ev[p] = m_drv[p]; et[4*p +: 4] = m_trig[p];
        end
        total++;
        if (pin_oe !== eo || pin_out !== ev || pin_trig !== et) begin
            bad++;
            $display("FAIL %s actual oe=%h out=%h expected oe=%h out=%h", req, pin_oe, pin_out, eo, ev);
        end
    endtask

    task automatic set_inputs(logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd1234));
        for (int p = 0; p < N; p++) begin
            m_drv[p] = 1'b0; m_txd[p] = 1'b1; m_rxd[p] = 1'b0; m_trig[p] = 4'd2;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6 reset contents, R7 reset pin vectors
        check32("R9 no valid idle", 32'(bus_rvalid), 32'd0);
        check_pins("R7 reset pins");
        do_read(PADB, rd);         check32("R6 reset word pin0", rd, 32'h0080_0008);
        do_read(PADB + 4*77, rd);  check32("R6 reset word pin77", rd, 32'h0080_0008);

        // R1 pointer and write ignored
        do_read(0, rd);            check32("R1 pointer", rd, PADB);
        do_write(0, 32'hFFFF_FFFF);
        do_read(0, rd);            check32("R1 pointer after write", rd, PADB);

        // R2 lock words
        for (int k = 0; k < 4; k++) begin
            do_read(LOCKB + 4*k, rd); check32("R2 lock word", rd, LOCKS[32*k +: 32]);
        end
        do_write(LOCKB + 8, 32'h0);
        do_read(LOCKB + 8, rd);    check32("R2 lock read-only", rd, LOCKS[64 +: 32]);

        // R4 field packing, R5 bit1 write ignored
        pad_write(5, 32'hFFFF_FFFF);
        do_read(PADB + 20, rd);    check32("R4 all ones packs", rd, 32'h03C0_0019);
        check_pins("R7 after write");
        pad_write(5, 32'h0040_0002);
        do_read(PADB + 20, rd);    check32("R5 bit1 write ignored", rd, 32'h0040_0000);

        // R3 locked pins
        pad_write(1, 32'h0000_0001);
        do_read(PADB + 4, rd);     check32("R3 locked pin1", rd, 32'h0080_0008);
        pad_write(127, 32'h0040_0001);
        do_read(PADB + 4*127, rd); check32("R3 locked pin127", rd, 32'h0080_0008);
        check_pins("R3 locked pins unchanged");

        // R5 synchronised input
        set_inputs({N{1'b1}});
        do_read(PADB + 4*9, rd);   check32("R5 input high", rd, exp_word(9));
        do_read(PADB + 4, rd);     check32("R5 input on locked pin", rd, 32'h0080_000A);
        @(negedge clk); pin_in[9] = 1'b0;
        do_read(PADB + 4*9, rd);   check32("R5 two-flop delay", rd, 32'h0080_000A);

        // R8 unmapped
        do_read(32'h0FC, rd);      check32("R8 gap reads zero", rd, 32'h0);
        do_write(32'h300, 32'hFFFF_FFFF);
        do_read(32'h300, rd);      check32("R8 above pads zero", rd, 32'h0);
        check_pins("R8 write changed nothing");

        // R9 back-to-back and trailing
        @(negedge clk); bus_rd = 1'b1; bus_addr = 12'(PADB + 4*5);
        @(negedge clk); bus_addr = 12'h000;
        check32("R9 chained first", bus_rdata, exp_word(5));
        @(negedge clk); bus_rd = 1'b0;
        check32("R9 chained second", bus_rdata, PADB);
        @(negedge clk);
        check32("R9 valid drops", 32'(bus_rvalid), 32'd0);

        // random mix, R3 R4 R5 R7
        for (int it = 0; it < 400; it++) begin
            int p;
            p = int'($urandom_range(0, N - 1));
            if ($urandom_range(0, 7) == 0)
                set_inputs({$urandom, $urandom, $urandom, $urandom});
            pad_write(p, $urandom);
            check_pins("R7 random pins");
            p = int'($urandom_range(0, N - 1));
            do_read(PADB + 4*p, rd);
            check32(LOCKS[p] ? "R3 random word" : "R4 random word", rd, exp_word(p));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule